// File: doc/BRIEF.md
# Chainable Unsigned Magnitude Comparator

This block compares two unsigned words and reports which one is larger, or that they match, on three separate result lines: greater, equal and less. It is built from identical four-bit slices. Each slice decides on its own nibble when the nibbles differ. When they match, the slice passes on the verdict it receives from the slice below it.

The top module chains a parameterised number of slices. The lowest slice takes its three incoming verdict lines from the top-level cascade ports, so a whole chain can itself be extended from below. To use the chain on its own, drive the incoming "equal" line high and the other two low. The logic is purely combinational and holds no registers.

Top module: `cmp_chain`

## Requirements
- R1: When `a_i` is greater than `b_i` as unsigned numbers, `gt_o` is 1 and `eq_o` and `lt_o` are 0. When `a_i` is less than `b_i`, `lt_o` is 1 and the other two are 0.
- R2: The most significant bit position where the operands differ decides the result, whatever the lower bits hold. For example, 0x80 against 0x7F gives greater.
- R3: When the operands differ, the three cascade inputs have no effect on the outputs. This holds for every pattern on them, including patterns with several lines high or none high.
- R4: When the operands are equal, `gt_o`, `eq_o` and `lt_o` copy `cas_gt_i`, `cas_eq_i` and `cas_lt_i` bit for bit. This holds for illegal patterns too.
- R5: With `cas_eq_i` high and the other two cascade inputs low, the outputs equal a plain unsigned compare for every pair of 8-bit operands.
- R6: Whenever exactly one cascade input is high, exactly one output is high.
- R7: A difference in a more significant nibble overrides the result of any less significant nibble. For example, 0x21 against 0x1F gives greater.
- R8: When the upper nibbles match, the result is the verdict of the lower nibble, carried up through the cascade path between slices.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | NIB_W*STAGES (8) | Operand A, unsigned |
| b_i | input | NIB_W*STAGES (8) | Operand B, unsigned |
| cas_gt_i | input | 1 | Incoming "greater" verdict from a lower chain |
| cas_eq_i | input | 1 | Incoming "equal" verdict from a lower chain |
| cas_lt_i | input | 1 | Incoming "less" verdict from a lower chain |
| gt_o | output | 1 | A is greater than B |
| eq_o | output | 1 | A equals B (after cascade) |
| lt_o | output | 1 | A is less than B |

## Verification
The block holds no state, so any wrong internal signal shows at the ports in the same cycle that exposes it. Examples are a broken bit-match line, a wrong scan order in a slice, or a cascade link wired to the wrong slice. A match line stuck at 1 makes one operand pair report equal or pass the cascade through, where it should decide locally. A scan that starts at the wrong end flips the verdict for pairs whose upper and lower differences disagree. The sweep of every 8-bit pair, together with cascade patterns applied under both equal and unequal operands, exposes each of these faults in the cycle where the first affected pair is applied.

// File: rtl/cmp_pkg.sv
package cmp_pkg;

    // Three-line verdict passed between slices.
    typedef struct packed {
        logic gt;
        logic eq;
        logic lt;
    } verdict_t;

endpackage

// File: rtl/cmp_bit_match.sv
// Per-bit equality lines (XNOR) and their AND.
module cmp_bit_match #(
    parameter int W = 4
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic [W-1:0] match_o,
    output logic         all_o
);

    for (genvar g = 0; g < W; g++) begin : g_bit
        assign match_o[g] = ~(a_i[g] ^ b_i[g]);
    end

    assign all_o = &match_o;

endmodule

// File: rtl/cmp_local_mag.sv
// Decides greater/less from the highest bit where the operands disagree.
module cmp_local_mag #(
    parameter int W = 4
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] match_i,
    output logic         gt_o,
    output logic         lt_o
);

    always_comb begin
        logic found;
        found = 1'b0;
        gt_o  = 1'b0;
        lt_o  = 1'b0;
        for (int i = W - 1; i >= 0; i--) begin
            if (!found && !match_i[i]) begin
                found = 1'b1;
                gt_o  = a_i[i];
                lt_o  = ~a_i[i];
            end
        end
    end

endmodule

// File: rtl/cmp_slice.sv
// One slice: local decision, or pass-through of the lower verdict on a tie.
module cmp_slice
    import cmp_pkg::*;
#(
    parameter int W = 4
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  verdict_t     cas_i,
    output verdict_t     res_o
);

    logic [W-1:0] match;
    logic         tie;
    logic         loc_gt;
    logic         loc_lt;

    cmp_bit_match #(.W(W)) u_match (
        .a_i     (a_i),
        .b_i     (b_i),
        .match_o (match),
        .all_o   (tie)
    );

    cmp_local_mag #(.W(W)) u_mag (
        .a_i     (a_i),
        .match_i (match),
        .gt_o    (loc_gt),
        .lt_o    (loc_lt)
    );

    always_comb begin
        if (tie) begin
            res_o = cas_i;
        end else begin
            res_o.gt = loc_gt;
            res_o.eq = 1'b0;
            res_o.lt = loc_lt;
        end
    end

    always_comb begin
        if (a_i > b_i) begin
            assert_slice_gt_R1: assert (res_o.gt && !res_o.eq && !res_o.lt);
        end
        if (a_i < b_i) begin
            assert_slice_lt_R1: assert (res_o.lt && !res_o.eq && !res_o.gt);
        end
        if (a_i == b_i) begin
            assert_slice_copy_R4: assert (res_o == cas_i);
        end
        if ($countones(cas_i) == 1) begin
            assert_slice_onehot_R6: assert ($countones(res_o) == 1);
        end
    end

endmodule

// File: rtl/cmp_chain.sv
// Chain of slices; slice 0 is least significant and takes the top cascade inputs.
module cmp_chain
    import cmp_pkg::*;
#(
    parameter int NIB_W  = 4,
    parameter int STAGES = 2
) (
    input  logic [NIB_W*STAGES-1:0] a_i,
    input  logic [NIB_W*STAGES-1:0] b_i,
    input  logic                    cas_gt_i,
    input  logic                    cas_eq_i,
    input  logic                    cas_lt_i,
    output logic                    gt_o,
    output logic                    eq_o,
    output logic                    lt_o
);

    localparam int W = NIB_W * STAGES;

    verdict_t link [STAGES+1];

    assign link[0] = '{gt: cas_gt_i, eq: cas_eq_i, lt: cas_lt_i};

    for (genvar s = 0; s < STAGES; s++) begin : g_slice
        cmp_slice #(.W(NIB_W)) u_slice (
            .a_i   (a_i[s*NIB_W +: NIB_W]),
            .b_i   (b_i[s*NIB_W +: NIB_W]),
            .cas_i (link[s]),
            .res_o (link[s+1])
        );
    end

    assign gt_o = link[STAGES].gt;
    assign eq_o = link[STAGES].eq;
    assign lt_o = link[STAGES].lt;

    always_comb begin
        if (cas_eq_i && !cas_gt_i && !cas_lt_i) begin
            assert_chain_plain_R5: assert (gt_o == (a_i > b_i) && lt_o == (a_i < b_i)
                                           && eq_o == (a_i == b_i));
        end
        if (a_i != b_i) begin
            assert_chain_ignore_R3: assert (!eq_o && (gt_o ^ lt_o));
        end
        if (a_i == b_i) begin
            assert_chain_copy_R4: assert (gt_o == cas_gt_i && eq_o == cas_eq_i
                                          && lt_o == cas_lt_i);
        end
    end

endmodule

// File: tb/cmp_chain_test.sv
`timescale 1ns/1ps
module cmp_chain_test;

    localparam int W = 8;

    typedef struct {
        logic [2:0] exp;   // {gt, eq, lt}
        string      tag;
        logic [W-1:0] a;
        logic [W-1:0] b;
    } item_t;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] a = '0;
    logic [W-1:0] b = '0;
    logic         cgt = 1'b0;
    logic         ceq = 1'b1;
    logic         clt = 1'b0;
    logic         gt, eq, lt;

    int checks = 0;
    int fails  = 0;
    item_t q[$];

    always #2.5 clk = ~clk;

    cmp_chain uut (
        .a_i      (a),
        .b_i      (b),
        .cas_gt_i (cgt),
        .cas_eq_i (ceq),
        .cas_lt_i (clt),
        .gt_o     (gt),
        .eq_o     (eq),
        .lt_o     (lt)
    );

    function automatic logic [2:0] model(logic [W-1:0] x, logic [W-1:0] y, logic [2:0] c);
        if (x > y) return 3'b100;
        if (x < y) return 3'b001;
        return c;
    endfunction

    task automatic apply(logic [W-1:0] x, logic [W-1:0] y, logic [2:0] c, string tag);
        item_t it;
        @(posedge clk);
        #1;
        a = x; b = y; {cgt, ceq, clt} = c;
        it.exp = model(x, y, c);
        it.tag = tag;
        it.a = x;
        it.b = y;
        q.push_back(it);
    endtask

    // Monitor: compares the settled outputs at the falling edge.
    always @(negedge clk) begin
        if (q.size() > 0) begin
            item_t it;
            it = q.pop_front();
            checks++;
            if ({gt, eq, lt} !== it.exp) begin
                fails++;
                $display("FAIL %s a=%h b=%h actual=%b expected=%b",
                         it.tag, it.a, it.b, {gt, eq, lt}, it.exp);
            end
        end
    end

    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            fails++;
            checks++;
            $display("FAIL watchdog actual=%0d expected<=150000 cycles", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        // Reset state: zero operands, plain cascade -> equal (R5)
        apply(8'h00, 8'h00, 3'b010, "R5");
        // R1 basic
        apply(8'h05, 8'h03, 3'b010, "R1");
        apply(8'h03, 8'h05, 3'b010, "R1");
        // R2 msb decides
        apply(8'h80, 8'h7F, 3'b010, "R2");
        apply(8'h7F, 8'h80, 3'b010, "R2");
        apply(8'h08, 8'h07, 3'b010, "R2");
        // R3 cascade ignored on difference, all eight patterns
        for (int c = 0; c < 8; c++) begin
            apply(8'hA4, 8'hA3, c[2:0], "R3");
            apply(8'h3A, 8'h4A, c[2:0], "R3");
        end
        // R4 copy on equality, all eight patterns
        for (int c = 0; c < 8; c++) begin
            apply(8'h5C, 8'h5C, c[2:0], "R4");
        end
        // R6 one-hot in -> one-hot out
        apply(8'hFF, 8'hFF, 3'b100, "R6");
        apply(8'hFF, 8'hFF, 3'b001, "R6");
        apply(8'h10, 8'h11, 3'b100, "R6");
        // R7 upper nibble overrides lower
        apply(8'h21, 8'h1F, 3'b010, "R7");
        apply(8'h1F, 8'h21, 3'b010, "R7");
        // R8 tie upper, lower decides through the link
        apply(8'h6E, 8'h62, 3'b010, "R8");
        apply(8'h62, 8'h6E, 3'b001, "R8");
        // R5 exhaustive sweep
        for (int x = 0; x < 256; x++) begin
            for (int y = 0; y < 256; y++) begin
                apply(x[7:0], y[7:0], 3'b010, "R5");
            end
        end
        while (q.size() > 0) @(negedge clk);
        @(posedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule